// File: doc/BRIEF.md
# H-Bridge Control and Fault Sequencer

This block is the digital control core of one brushed-DC H-bridge. It turns two host command inputs into gate enables for the high-side and low-side switch of each of the two half-bridge legs. A parameter picks how the two inputs are read: either as two independent leg commands, or as a direction bit plus an enable bit. Each leg ends up in one of three states: driven high, driven low, or both switches off (high impedance).

Around the decoder sit a sleep/wake sequencer and a fault supervisor. While the sleep input is low the bridge floats. After it rises, the bridge waits out a wake delay before it drives. Three fault flags come from upstream analog sensing: supply undervoltage, overcurrent and overtemperature. Undervoltage and overtemperature hold the bridge off only while they are asserted. Overcurrent must persist through a deglitch window before it trips. A trip then holds the bridge off for a fixed retry time, after which the bridge re-enables by itself. All durations are counted in clock cycles; with a 1 MHz clock the defaults are 1, 1000 and 30 cycles. A per-leg guard makes sure no leg ever goes straight from high to low or from low to high.

Top module: `hb_ctrl_seq`

## Requirements
- R1: With MODE_SEL=0, in_a/in_b = 0/0 leaves both legs off (coast), 1/0 drives leg 1 high and leg 2 low, 0/1 drives leg 1 low and leg 2 high, and 1/1 drives both legs low (brake). A leg driven high has gate_hs=1, gate_ls=0, out_hiz=0; a leg driven low has gate_hs=0, gate_ls=1, out_hiz=0; a leg that is off has both gates 0 and out_hiz=1. Bit 0 of each vector is leg 1.
- R2: With MODE_SEL=1, in_a is the direction and in_b the enable. Enable 0 drives both legs low. Enable 1 with direction 0 drives leg 1 high and leg 2 low; enable 1 with direction 1 drives leg 1 low and leg 2 high.
- R3: While sleep_n is low, both legs are off in either mode, whatever the other inputs are.
- R4: After sleep_n rises, both legs stay off until sleep_n has been high at WAKE_CYC consecutive rising edges; the commanded state appears at the following edge.
- R5: oc_flag trips the bridge only after it has been high at DEGLITCH_CYC consecutive edges; a shorter pulse has no effect on the outputs or on fault_stat.
- R6: After a trip, both legs stay off for RETRY_CYC cycles and then resume with no host action. oc_flag is ignored during that period.
- R7: While uv_flag is high, both legs are off; the commanded state returns at the edge after the flag clears.
- R8: While ot_flag is high, both legs are off; the commanded state returns at the edge after the flag clears.
- R9: fault_stat bit 0 reports undervoltage, bit 1 reports an overcurrent shutdown in progress, and bit 2 reports overtemperature. Each bit is registered, so it changes at the same edge as the gate outputs that the fault turns off.
- R10: gate_hs and gate_ls of one leg are never both 1. A leg that reverses spends exactly one cycle off in between.
- R11: Taking sleep_n low during a retry period cancels the retry. The next wake uses only the wake delay, and fault_stat bit 1 is clear.
- R12: Outputs are registered, so a command change shows at the next rising edge. Synchronous active-high rst turns every leg off, clears fault_stat and arms the wake delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n | input | 1 | Low puts the bridge to sleep |
| in_a | input | 1 | Leg 1 command, or direction bit |
| in_b | input | 1 | Leg 2 command, or enable bit |
| uv_flag | input | 1 | Supply undervoltage indication |
| oc_flag | input | 1 | Raw overcurrent indication |
| ot_flag | input | 1 | Overtemperature indication |
| gate_hs | output | 2 | High-side switch enable per leg |
| gate_ls | output | 2 | Low-side switch enable per leg |
| out_hiz | output | 2 | Leg has both switches off |
| fault_stat | output | 3 | {overtemperature, overcurrent shutdown, undervoltage} |

## Verification
The hardest state to reach from the ports is a sleep request that lands in the middle of an overcurrent retry, followed by a wake that must not inherit the old retry count. A directed sequence holds oc_flag long enough to trip, drops sleep_n part-way through the retry, raises it again, and checks that drive resumes after the wake delay rather than after the remaining retry time. Random stimulus adds overcurrent bursts whose lengths straddle the deglitch window, together with sleep and fault bursts. A cycle model in the bench follows every edge, so shutdowns that overlap each other are compared as well.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Leg drive state: both off, high-side on, low-side on
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_e;

    typedef struct packed {
        leg_e leg2;
        leg_e leg1;
    } bridge_t;

    typedef struct packed {
        logic ot;
        logic oc;
        logic uv;
    } fault_t;

    localparam int MODE_DUAL = 0;
    localparam int MODE_DIR_EN = 1;
    localparam int NUM_LEGS = 2;

    // Counter width able to hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // Two independent leg commands
    function automatic bridge_t decode_dual(input logic a, input logic b);
        bridge_t r;
        unique case ({a, b})
            2'b00:   r = '{leg2: LEG_OFF,  leg1: LEG_OFF};
            2'b10:   r = '{leg2: LEG_LOW,  leg1: LEG_HIGH};
            2'b01:   r = '{leg2: LEG_HIGH, leg1: LEG_LOW};
            default: r = '{leg2: LEG_LOW,  leg1: LEG_LOW};
        endcase
        return r;
    endfunction

    // Direction plus enable
    function automatic bridge_t decode_dir_en(input logic dir, input logic en);
        bridge_t r;
        if (!en)
            r = '{leg2: LEG_LOW, leg1: LEG_LOW};
        else if (dir)
            r = '{leg2: LEG_HIGH, leg1: LEG_LOW};
        else
            r = '{leg2: LEG_LOW, leg1: LEG_HIGH};
        return r;
    endfunction

endpackage

// File: rtl/hb_input_decode.sv
module hb_input_decode
    import hb_pkg::*;
#(
    parameter int MODE_SEL = MODE_DUAL
) (
    input  logic    in_a,
    input  logic    in_b,
    output bridge_t req
);
    generate
        if (MODE_SEL == MODE_DIR_EN) begin : g_dir_en
            assign req = decode_dir_en(in_a, in_b);
        end else begin : g_dual
            assign req = decode_dual(in_a, in_b);
        end
    endgenerate
endmodule

// File: rtl/hb_wake_seq.sv
module hb_wake_seq
    import hb_pkg::*;
#(
    parameter int WAKE_CYC = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_n,
    output logic awake
);
    localparam int WW = cnt_width(WAKE_CYC);
    localparam logic [WW-1:0] WLAST = WW'(WAKE_CYC - 1);

    logic [WW-1:0] cnt_q;
    logic          awake_q;

    always_ff @(posedge clk) begin
        if (rst || !sleep_n) begin
            cnt_q   <= '0;
            awake_q <= 1'b0;
        end else if (!awake_q) begin
            if (cnt_q == WLAST)
                awake_q <= 1'b1;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign awake = awake_q;
endmodule

// File: rtl/hb_ocp_seq.sv
module hb_ocp_seq
    import hb_pkg::*;
#(
    parameter int DEGLITCH_CYC = 1,
    parameter int RETRY_CYC    = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_n,
    input  logic oc_flag,
    output logic tripped
);
    localparam int DW = cnt_width(DEGLITCH_CYC);
    localparam int RW = cnt_width(RETRY_CYC);
    localparam logic [DW-1:0] DLAST = DW'(DEGLITCH_CYC - 1);
    localparam logic [RW-1:0] RLAST = RW'(RETRY_CYC - 1);

    logic [DW-1:0] dg_q;
    logic [RW-1:0] rt_q;
    logic          trip_q;

    always_ff @(posedge clk) begin
        if (rst || !sleep_n) begin
            dg_q   <= '0;
            rt_q   <= '0;
            trip_q <= 1'b0;
        end else if (trip_q) begin
            // retry window: raw flag ignored
            if (rt_q == RLAST) begin
                trip_q <= 1'b0;
                dg_q   <= '0;
            end else begin
                rt_q <= rt_q + 1'b1;
            end
        end else if (oc_flag) begin
            if (dg_q == DLAST) begin
                trip_q <= 1'b1;
                rt_q   <= '0;
                dg_q   <= '0;
            end else begin
                dg_q <= dg_q + 1'b1;
            end
        end else begin
            dg_q <= '0;
        end
    end

    assign tripped = trip_q;
endmodule

// File: rtl/hb_leg_guard.sv
module hb_leg_guard
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  leg_e want,
    output leg_e state
);
    leg_e state_q;
    leg_e state_d;

    // A reversal is split into an off cycle followed by the new side
    always_comb begin
        if (state_q != LEG_OFF && want != LEG_OFF && want != state_q)
            state_d = LEG_OFF;
        else
            state_d = want;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= LEG_OFF;
        else
            state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/hb_ctrl_seq.sv
module hb_ctrl_seq
    import hb_pkg::*;
#(
    parameter int MODE_SEL     = MODE_DUAL,
    parameter int DEGLITCH_CYC = 1,
    parameter int RETRY_CYC    = 1000,
    parameter int WAKE_CYC     = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_n,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       uv_flag,
    input  logic       oc_flag,
    input  logic       ot_flag,
    output logic [1:0] gate_hs,
    output logic [1:0] gate_ls,
    output logic [1:0] out_hiz,
    output logic [2:0] fault_stat
);
    bridge_t req;
    logic    awake;
    logic    tripped;
    logic    blocked;
    leg_e    want  [NUM_LEGS];
    leg_e    state [NUM_LEGS];
    fault_t  fault_q;

    hb_input_decode #(.MODE_SEL(MODE_SEL)) u_dec (
        .in_a (in_a),
        .in_b (in_b),
        .req  (req)
    );

    hb_wake_seq #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk     (clk),
        .rst     (rst),
        .sleep_n (sleep_n),
        .awake   (awake)
    );

    hb_ocp_seq #(
        .DEGLITCH_CYC (DEGLITCH_CYC),
        .RETRY_CYC    (RETRY_CYC)
    ) u_ocp (
        .clk     (clk),
        .rst     (rst),
        .sleep_n (sleep_n),
        .oc_flag (oc_flag),
        .tripped (tripped)
    );

    assign blocked = !sleep_n || !awake || uv_flag || ot_flag || tripped;

    always_comb begin
        want[0] = blocked ? LEG_OFF : req.leg1;
        want[1] = blocked ? LEG_OFF : req.leg2;
    end

    generate
        for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
            hb_leg_guard u_guard (
                .clk   (clk),
                .rst   (rst),
                .want  (want[g]),
                .state (state[g])
            );
            assign gate_hs[g] = (state[g] == LEG_HIGH);
            assign gate_ls[g] = (state[g] == LEG_LOW);
            assign out_hiz[g] = (state[g] == LEG_OFF);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            fault_q <= '0;
        else
            fault_q <= '{ot: ot_flag, oc: tripped, uv: uv_flag};
    end

    assign fault_stat = fault_q;
endmodule

// File: rtl/hb_ctrl_chk.sv
module hb_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sleep_n,
    input logic       uv_flag,
    input logic       ot_flag,
    input logic [1:0] gate_hs,
    input logic [1:0] gate_ls,
    input logic [1:0] out_hiz,
    input logic [2:0] fault_stat
);
    generate
        for (genvar j = 0; j < 2; j++) begin : g_leg
            AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
                $onehot0({gate_hs[j], gate_ls[j]})); // R10
            AST_LOW_TO_HIGH_GAP: assert property (@(posedge clk) disable iff (rst)
                gate_ls[j] |=> !gate_hs[j]); // R10
            AST_HIGH_TO_LOW_GAP: assert property (@(posedge clk) disable iff (rst)
                gate_hs[j] |=> !gate_ls[j]); // R10
            AST_HIZ_NO_GATE: assert property (@(posedge clk) disable iff (rst)
                out_hiz[j] |-> !(gate_hs[j] || gate_ls[j])); // R1
        end
    endgenerate

    AST_SLEEP_FLOATS: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> (out_hiz == 2'b11)); // R3
    AST_UV_SHUTS_OFF: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> ((out_hiz == 2'b11) && fault_stat[0])); // R7
    AST_OT_SHUTS_OFF: assert property (@(posedge clk) disable iff (rst)
        ot_flag |=> ((out_hiz == 2'b11) && fault_stat[2])); // R8
    AST_OC_STATUS_OFF: assert property (@(posedge clk) disable iff (rst)
        fault_stat[1] |-> (out_hiz == 2'b11)); // R6
endmodule

bind hb_ctrl_seq hb_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_n    (sleep_n),
    .uv_flag    (uv_flag),
    .ot_flag    (ot_flag),
    .gate_hs    (gate_hs),
    .gate_ls    (gate_ls),
    .out_hiz    (out_hiz),
    .fault_stat (fault_stat)
);

// File: tb/tb_hb_ctrl_seq.sv
`timescale 1ns/1ps
module tb_hb_ctrl_seq;
    localparam int DG = 4;
    localparam int RT = 200;
    localparam int WK = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_n = 1'b0, in_a = 1'b0, in_b = 1'b0;
    logic uv = 1'b0, oc = 1'b0, ot = 1'b0;
    logic [1:0] hs [2];
    logic [1:0] ls [2];
    logic [1:0] hz [2];
    logic [2:0] fs [2];

    int checks = 0, errors = 0;
    bit done = 0, chk_en = 0;
    string tag = "";

    always #2.5 clk = ~clk;

    hb_ctrl_seq #(.MODE_SEL(0), .DEGLITCH_CYC(DG), .RETRY_CYC(RT), .WAKE_CYC(WK)) dut (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .in_a(in_a), .in_b(in_b),
        .uv_flag(uv), .oc_flag(oc), .ot_flag(ot),
        .gate_hs(hs[0]), .gate_ls(ls[0]), .out_hiz(hz[0]), .fault_stat(fs[0]));

    hb_ctrl_seq #(.MODE_SEL(1), .DEGLITCH_CYC(DG), .RETRY_CYC(RT), .WAKE_CYC(WK)) dut_de (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .in_a(in_a), .in_b(in_b),
        .uv_flag(uv), .oc_flag(oc), .ot_flag(ot),
        .gate_hs(hs[1]), .gate_ls(ls[1]), .out_hiz(hz[1]), .fault_stat(fs[1]));

    // ---- reference model: leg code 0 off, 1 high, 2 low ----
    int m_leg [2][2];
    bit m_awake [2], m_trip [2];
    int m_wc [2], m_dg [2], m_rt [2];
    bit [2:0] m_fault [2];

    function automatic int cmd(int k, bit a, bit b, int leg);
        if (k == 0) begin                       // R1 table
            if (!a && !b) return 0;
            if (a && b) return 2;
            if (leg == 0) return a ? 1 : 2;
            return b ? 1 : 2;
        end
        if (!b) return 2;                       // R2 table
        if (leg == 0) return a ? 2 : 1;
        return a ? 1 : 2;
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                m_leg[k][0] = 0; m_leg[k][1] = 0; m_awake[k] = 0; m_trip[k] = 0;
                m_wc[k] = 0; m_dg[k] = 0; m_rt[k] = 0; m_fault[k] = 3'b000;
            end else begin
                bit blk;
                blk = !sleep_n || !m_awake[k] || uv || ot || m_trip[k];
                for (int j = 0; j < 2; j++) begin
                    int w;
                    w = blk ? 0 : cmd(k, in_a, in_b, j);
                    if (m_leg[k][j] != 0 && w != 0 && w != m_leg[k][j]) m_leg[k][j] = 0;
                    else m_leg[k][j] = w;
                end
                m_fault[k] = {ot, m_trip[k], uv};
                if (!sleep_n) begin
                    m_awake[k] = 0; m_wc[k] = 0;
                    m_trip[k] = 0; m_dg[k] = 0; m_rt[k] = 0;
                end else begin
                    if (!m_awake[k]) begin
                        if (m_wc[k] == WK - 1) m_awake[k] = 1; else m_wc[k]++;
                    end
                    if (m_trip[k]) begin
                        if (m_rt[k] == RT - 1) begin m_trip[k] = 0; m_dg[k] = 0; end
                        else m_rt[k]++;
                    end else if (oc) begin
                        if (m_dg[k] == DG - 1) begin m_trip[k] = 1; m_rt[k] = 0; m_dg[k] = 0; end
                        else m_dg[k]++;
                    end else m_dg[k] = 0;
                end
            end
        end
    end

    function automatic string ctx(int k);
        if (tag != "") return tag;
        if (!sleep_n) return "R3";
        if (m_fault[k][0]) return "R7";
        if (m_fault[k][2]) return "R8";
        if (m_fault[k][1]) return "R6";
        if (!m_awake[k]) return "R4";
        return (k == 0) ? "R1" : "R2";
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model, sampled at the falling edge
    always @(negedge clk) begin
        if (!rst && chk_en) begin
            for (int k = 0; k < 2; k++) begin
                logic [5:0] e;
                for (int j = 0; j < 2; j++) begin
                    e[j]     = (m_leg[k][j] == 1);
                    e[2 + j] = (m_leg[k][j] == 2);
                    e[4 + j] = (m_leg[k][j] == 0);
                end
                check(ctx(k), {2'b00, hz[k], ls[k], hs[k]}, {2'b00, e});
                check("R9", {5'b0, fs[k]}, {5'b0, m_fault[k]});
                check("R10", {7'b0, |(hs[k] & ls[k])}, 8'h00);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    int oc_left = 0, uv_left = 0, ot_left = 0, sl_left = 0;
    task automatic rnd(int n);
        repeat (n) begin
            @(negedge clk);
            if ($urandom % 7 == 0) in_a = 1'($urandom);
            if ($urandom % 7 == 0) in_b = 1'($urandom);
            if (oc_left > 0) oc_left--; else if ($urandom % 50 == 0) oc_left = 1 + int'($urandom % (DG + 3));
            if (uv_left > 0) uv_left--; else if ($urandom % 150 == 0) uv_left = 1 + int'($urandom % 6);
            if (ot_left > 0) ot_left--; else if ($urandom % 150 == 0) ot_left = 1 + int'($urandom % 6);
            if (sl_left > 0) sl_left--; else if ($urandom % 400 == 0) sl_left = 1 + int'($urandom % 20);
            oc = (oc_left > 0); uv = (uv_left > 0); ot = (ot_left > 0); sleep_n = (sl_left == 0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog actual=hung expected=completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h00C0_FFEE));
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R12: reset state (sleep low, so also floating)
        for (int k = 0; k < 2; k++)
            check("R12", {hz[k], ls[k], hs[k], fs[k][1:0]}, {2'b11, 2'b00, 2'b00, 2'b00});
        chk_en = 1;

        // R4: wake delay with a drive command pending
        tag = "R4"; in_a = 1; in_b = 0; sleep_n = 1;
        cyc(WK);
        check("R4", {6'b0, hz[0]}, 8'h03);
        cyc(2);
        check("R4", {6'b0, hz[0]}, 8'h00);

        // R1 / R2: walk every input combination, both orders
        tag = "";
        for (int v = 0; v < 4; v++) begin in_a = v[1]; in_b = v[0]; cyc(3); end
        for (int v = 3; v >= 0; v--) begin in_a = v[0]; in_b = v[1]; cyc(3); end

        // R10: direct reversal
        tag = "R10";
        in_a = 1; in_b = 0; cyc(3);
        in_a = 0; in_b = 1; cyc(1);
        check("R10", {6'b0, hz[0]}, 8'h03);
        cyc(2);

        // R5: pulse one short of the window is ignored
        tag = "R5"; in_a = 1; in_b = 0;
        oc = 1; cyc(DG - 1); oc = 0; cyc(3);
        check("R5", {5'b0, fs[0]}, 8'h00);
        check("R5", {6'b0, hz[0]}, 8'h00);

        // R6: full trip then automatic retry
        tag = "R6";
        oc = 1; cyc(DG + 2); oc = 0;
        check("R6", {7'b0, fs[0][1]}, 8'h01);
        cyc(RT + 4);
        check("R6", {6'b0, hz[0]}, 8'h00);

        // R11: sleep during retry cancels it
        tag = "R11";
        oc = 1; cyc(DG + 1); oc = 0; cyc(20);
        sleep_n = 0; cyc(3); sleep_n = 1;
        cyc(WK + 2);
        check("R11", {5'b0, fs[0]}, 8'h00);
        check("R11", {6'b0, hz[0]}, 8'h00);

        // R7 / R8 / R9: supply and temperature flags
        tag = "R7"; uv = 1; cyc(2);
        check("R9", {5'b0, fs[1]}, 8'h01);
        uv = 0; cyc(3);
        tag = "R8"; ot = 1; cyc(2);
        check("R9", {5'b0, fs[1]}, 8'h04);
        ot = 0; cyc(3);

        // R3: sleep while driving
        tag = "R3"; sleep_n = 0; cyc(2);
        check("R3", {4'b0, hz[1], hz[0]}, 8'h0F);
        sleep_n = 1; cyc(WK + 3);

        // mixed random traffic
        tag = "";
        rnd(6000);

        done = 1;
        finish_run();
    end
endmodule